// File: doc/BRIEF.md
# Configurable SYNC Event Generator

This block turns an external SYNC request, along with optional lock conditions from two PLLs, into one of two internal controls. The first is a hold level that keeps the clock dividers in sync. The second is a single-cycle start strobe for a downstream SYSREF pulser.

An 8-bit control register sets how a request is interpreted:
- whether the input is inverted;
- whether the function is enabled;
- whether the input acts as a level or as an edge that starts a fixed-length hold;
- whether each PLL's missing lock keeps the request asserted;
- which of four routing modes applies.

In the software-trigger mode, the pulser is started only by a write to a separate pulse-count address.

The SYNC input and both lock indicators are brought into the clock domain through a multi-stage synchroniser before any processing. Both outputs are registered. A register write takes effect from the following clock.

Top module: `sync_event_gen`

## Requirements
- R1: After reset, the control readback is 0x01 (mode 1, every other bit 0), and `div_sync_o`, `pulse_start_o` and `sysref_clr_o` are 0.
- R2: A write to address 0 loads `wr_data_i` into the control register, and it reads back on `ctrl_o` from the next cycle. A write to address 1 (pulse-count) leaves the control register unchanged.
- R3: With control bit 4 (enable) at 0, both `div_sync_o` and `pulse_start_o` stay 0 whatever the pin, lock or pulse-count activity.
- R4: In mode 1 (bits 1:0 = 1) with bit 6 (one-shot) at 0, `div_sync_o` follows the SYNC pin level. The latency is three clocks: two synchroniser stages and one output register.
- R5: With bit 5 (invert) at 1, the pin is inverted before all other processing, so a low pin asserts the hold.
- R6: With bit 6 at 1, each rising edge of the corrected SYNC holds `div_sync_o` high for exactly HOLD_CYCLES clocks (default 8), whatever the width of the input pulse.
- R7: With bit 2 set, `div_sync_o` stays asserted while `pll1_lock_i` is 0 and releases once it is 1. The `pll2_lock_i` input has no effect while bit 3 is clear.
- R8: With bit 3 set, `div_sync_o` stays asserted while `pll2_lock_i` is 0 and releases once it is 1.
- R9: In mode 0, neither the pin nor the lock conditions produce any output.
- R10: In mode 2, each rising edge of the combined request (pin or lock condition) gives exactly one single-cycle `pulse_start_o`, and `div_sync_o` stays 0.
- R11: In mode 3, each write to address 1 gives one `pulse_start_o` cycle on the next clock. Pin activity produces no pulse and no hold.
- R12: `sysref_clr_o` mirrors control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address (0 control, 1 pulse-count) |
| wr_data_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control register readback |
| sync_pin_i | input | 1 | Asynchronous SYNC request |
| pll1_lock_i | input | 1 | PLL1 lock indicator, asynchronous |
| pll2_lock_i | input | 1 | PLL2 lock indicator, asynchronous |
| div_sync_o | output | 1 | Divider sync hold level |
| pulse_start_o | output | 1 | Single-cycle pulser start strobe |
| sysref_clr_o | output | 1 | Copy of the SYSREF clear control bit |

## Verification
The bench measures the exact length of the one-shot hold for both a one-cycle and a long pin pulse. A design that tied the hold to the input width, or had an off-by-one in the counter, would give 1, 7, 9 or unbounded cycles.

It counts strobes in the pulser modes. A level-driven strobe would repeat while the request stays high. A mode 3 design that listened to the pin would produce extra pulses.

Lock gating is tested with the other PLL's lock held low. This exposes a swapped or merged gate. The invert and latency checks sample on exact cycles, to catch a missing or extra register stage.

// File: rtl/sync_event_pkg.sv
package sync_event_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_DIRECT = 2'd1,
    MODE_PULSER = 2'd2,
    MODE_SWTRIG = 2'd3
  } sync_mode_e;

  typedef struct packed {
    logic       ref_clear;
    logic       one_shot;
    logic       invert;
    logic       enable;
    logic       gate_pll2;
    logic       gate_pll1;
    sync_mode_e mode;
  } sync_ctrl_t;

  localparam int unsigned CtrlW = $bits(sync_ctrl_t);
  localparam logic [CtrlW-1:0] CtrlReset = 8'h01;

endpackage

// File: rtl/sync_event_regs.sv
module sync_event_regs
  import sync_event_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] PCNT_ADDR = ADDR_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CtrlW-1:0]  wr_data_i,
  output sync_ctrl_t        ctrl_o,
  output logic              pcnt_wr_o
);

  logic [CtrlW-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ctrl_q <= CtrlReset;
    else if (wr_en_i && wr_addr_i == CTRL_ADDR) ctrl_q <= wr_data_i;
  end

  assign ctrl_o    = sync_ctrl_t'(ctrl_q);
  assign pcnt_wr_o = wr_en_i && (wr_addr_i == PCNT_ADDR);

endmodule

// File: rtl/sync_event_cdc.sv
module sync_event_cdc #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else         pipe_q[s] <= (s == 0) ? d_i : pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sync_event_oneshot.sv
module sync_event_oneshot #(
  parameter int unsigned HOLD_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);

  localparam int unsigned CntW = $clog2(HOLD_CYCLES + 1);

  logic [CntW-1:0] cnt_q;

  // a new edge reloads the full hold time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (trig_i)     cnt_q <= CntW'(HOLD_CYCLES);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

endmodule

// File: rtl/sync_event_gen.sv
module sync_event_gen
  import sync_event_pkg::*;
#(
  parameter int unsigned       HOLD_CYCLES = 8,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       ADDR_W      = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] PCNT_ADDR   = ADDR_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        ctrl_o,
  input  logic              sync_pin_i,
  input  logic              pll1_lock_i,
  input  logic              pll2_lock_i,
  output logic              div_sync_o,
  output logic              pulse_start_o,
  output logic              sysref_clr_o
);

  sync_ctrl_t ctrl;
  logic       pcnt_wr;
  logic [2:0] async_in, synced;
  logic       pin_s, lock1_s, lock2_s;
  logic       sync_c, sync_c_q, sync_rise;
  logic       os_active, pin_req, lock_hold, base_req, base_req_q;
  logic       live, div_d, pulse_d;

  sync_event_regs #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .PCNT_ADDR(PCNT_ADDR)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .ctrl_o   (ctrl),
    .pcnt_wr_o(pcnt_wr)
  );

  assign async_in = {pll2_lock_i, pll1_lock_i, sync_pin_i};

  sync_event_cdc #(
    .WIDTH (3),
    .STAGES(SYNC_STAGES)
  ) u_cdc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_in),
    .q_o   (synced)
  );

  assign {lock2_s, lock1_s, pin_s} = synced;

  assign sync_c    = pin_s ^ ctrl.invert;
  assign sync_rise = sync_c & ~sync_c_q;

  sync_event_oneshot #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_oneshot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (sync_rise & ctrl.one_shot),
    .active_o(os_active)
  );

  assign pin_req   = ctrl.one_shot ? os_active : sync_c;
  assign lock_hold = (ctrl.gate_pll1 & ~lock1_s) | (ctrl.gate_pll2 & ~lock2_s);
  assign base_req  = pin_req | lock_hold;
  assign live      = ctrl.enable && (ctrl.mode != MODE_OFF);

  always_comb begin
    div_d   = 1'b0;
    pulse_d = 1'b0;
    if (live) begin
      unique case (ctrl.mode)
        MODE_DIRECT: div_d   = base_req;
        MODE_PULSER: pulse_d = base_req & ~base_req_q;
        MODE_SWTRIG: pulse_d = pcnt_wr;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_c_q      <= 1'b0;
      base_req_q    <= 1'b0;
      div_sync_o    <= 1'b0;
      pulse_start_o <= 1'b0;
    end else begin
      sync_c_q      <= sync_c;
      base_req_q    <= base_req;
      div_sync_o    <= div_d;
      pulse_start_o <= pulse_d;
    end
  end

  assign ctrl_o       = ctrl;
  assign sysref_clr_o = ctrl.ref_clear;

endmodule

// File: rtl/sync_event_gen_checker.sv
module sync_event_gen_checker #(
  parameter int unsigned       ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] PCNT_ADDR = ADDR_W'(1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic [7:0]        ctrl_o,
  input logic              div_sync_o,
  input logic              pulse_start_o,
  input logic              sysref_clr_o
);

  a_r2_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CTRL_ADDR) |=> (ctrl_o == $past(wr_data_i)));

  a_r3_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[4] |=> (!div_sync_o && !pulse_start_o));

  a_r9_mode0_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[1:0] == 2'd0) |=> (!div_sync_o && !pulse_start_o));

  a_r10_no_hold_in_pulser_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[1] |=> !div_sync_o);

  a_r11_write_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[4] && ctrl_o[1:0] == 2'd3 && wr_en_i && wr_addr_i == PCNT_ADDR) |=> pulse_start_o);

  a_r11_only_write_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[1:0] == 2'd3 && !(wr_en_i && wr_addr_i == PCNT_ADDR)) |=> !pulse_start_o);

  a_r12_clear_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysref_clr_o == ctrl_o[7]);

endmodule

bind sync_event_gen sync_event_gen_checker #(
  .ADDR_W   (ADDR_W),
  .CTRL_ADDR(CTRL_ADDR),
  .PCNT_ADDR(PCNT_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .ctrl_o       (ctrl_o),
  .div_sync_o   (div_sync_o),
  .pulse_start_o(pulse_start_o),
  .sysref_clr_o (sysref_clr_o)
);

// File: tb/sync_event_gen_test.sv
module sync_event_gen_test;

  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl;
  logic       pin = 1'b0, lock1 = 1'b1, lock2 = 1'b1;
  logic       div_sync, pulse_start, sysref_clr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sync_event_gen #(.HOLD_CYCLES(HOLD)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .ctrl_o       (ctrl),
    .sync_pin_i   (pin),
    .pll1_lock_i  (lock1),
    .pll2_lock_i  (lock2),
    .div_sync_o   (div_sync),
    .pulse_start_o(pulse_start),
    .sysref_clr_o (sysref_clr)
  );

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // samples n negedges, returns high count of div_sync and pulse_start
  task automatic observe(input int n, output int div_hi, output int pulses);
    div_hi = 0; pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (div_sync) div_hi++;
      if (pulse_start) pulses++;
    end
  endtask

  task automatic idle_all();
    pin = 1'b0; lock1 = 1'b1; lock2 = 1'b1;
    reg_write(2'd0, 8'h01);
    wait_cyc(5);
  endtask

  task automatic t_reset();
    check("R1 ctrl reset", ctrl, 8'h01);
    check("R1 div reset", div_sync, 0);
    check("R1 pulse reset", pulse_start, 0);
    check("R1 clr reset", sysref_clr, 0);
  endtask

  task automatic t_regs();
    reg_write(2'd0, 8'hA5);
    check("R2 ctrl readback", ctrl, 8'hA5);
    reg_write(2'd1, 8'h3C);
    check("R2 pcnt write leaves ctrl", ctrl, 8'hA5);
    check("R12 clr mirrors bit7", sysref_clr, 1);
    reg_write(2'd0, 8'h01);
    check("R12 clr cleared", sysref_clr, 0);
  endtask

  task automatic t_disabled();
    int d, p;
    reg_write(2'd0, 8'h0D);
    pin = 1'b1; lock1 = 1'b0; lock2 = 1'b0;
    observe(8, d, p);
    check("R3 disabled no hold", d, 0);
    reg_write(2'd0, 8'h03);
    reg_write(2'd1, 8'h01);
    observe(4, d, p);
    check("R3 disabled no strobe", p, 0);
    idle_all();
  endtask

  task automatic t_level();
    int d, p;
    reg_write(2'd0, 8'h11);
    wait_cyc(4);
    pin = 1'b1;
    wait_cyc(2);
    check("R4 not yet after two edges", div_sync, 0);
    wait_cyc(1);
    check("R4 high after three edges", div_sync, 1);
    observe(20, d, p);
    check("R4 held while level high", d, 20);
    pin = 1'b0;
    wait_cyc(3);
    check("R4 release follows pin", div_sync, 0);
  endtask

  task automatic t_invert();
    int d, p;
    reg_write(2'd0, 8'h31);
    pin = 1'b0;
    wait_cyc(4);
    check("R5 low pin asserts", div_sync, 1);
    pin = 1'b1;
    observe(10, d, p);
    wait_cyc(3);
    check("R5 high pin releases", div_sync, 0);
    idle_all();
  endtask

  task automatic t_oneshot();
    int d, p;
    reg_write(2'd0, 8'h51);
    wait_cyc(4);
    @(negedge clk); pin = 1'b1;
    @(negedge clk); pin = 1'b0;
    observe(30, d, p);
    check("R6 short pulse hold length", d, HOLD);
    pin = 1'b1;
    observe(40, d, p);
    check("R6 long pulse hold length", d, HOLD);
    idle_all();
  endtask

  task automatic t_lock1();
    int d, p;
    reg_write(2'd0, 8'h15);
    lock2 = 1'b0;
    wait_cyc(5);
    check("R7 pll2 ignored when ungated", div_sync, 0);
    lock1 = 1'b0;
    wait_cyc(5);
    check("R7 held while pll1 unlocked", div_sync, 1);
    lock1 = 1'b1;
    wait_cyc(5);
    check("R7 released on pll1 lock", div_sync, 0);
    idle_all();
  endtask

  task automatic t_lock2();
    reg_write(2'd0, 8'h19);
    lock2 = 1'b0;
    wait_cyc(5);
    check("R8 held while pll2 unlocked", div_sync, 1);
    lock2 = 1'b1;
    wait_cyc(5);
    check("R8 released on pll2 lock", div_sync, 0);
    idle_all();
  endtask

  task automatic t_mode0();
    int d, p;
    reg_write(2'd0, 8'h1C);
    pin = 1'b1; lock1 = 1'b0; lock2 = 1'b0;
    observe(10, d, p);
    check("R9 mode0 no hold", d, 0);
    check("R9 mode0 no strobe", p, 0);
    idle_all();
  endtask

  task automatic t_pulser();
    int d, p, dt, pt;
    dt = 0; pt = 0;
    reg_write(2'd0, 8'h12);
    wait_cyc(4);
    for (int k = 0; k < 3; k++) begin
      pin = 1'b1;
      observe(10, d, p); dt += d; pt += p;
      pin = 1'b0;
      observe(10, d, p); dt += d; pt += p;
    end
    check("R10 one strobe per edge", pt, 3);
    check("R10 no hold in pulser mode", dt, 0);
    idle_all();
  endtask

  task automatic t_swtrig();
    int d, p, pt;
    reg_write(2'd0, 8'h13);
    pin = 1'b1;
    observe(6, d, p);
    pin = 1'b0;
    observe(6, d, p);
    check("R11 pin ignored", p + d, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h04;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 strobe next clock", pulse_start, 1);
    @(negedge clk);
    check("R11 strobe single cycle", pulse_start, 0);
    reg_write(2'd1, 8'h02);
    observe(6, d, pt);
    check("R11 no extra strobe", pt, 0);
    idle_all();
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(2);
    t_regs();
    t_disabled();
    t_level();
    t_invert();
    t_oneshot();
    t_lock1();
    t_lock2();
    t_mode0();
    t_pulser();
    t_swtrig();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule